// File: doc/BRIEF.md
# Strobe-Aware Write Burst Splitter

This block sits between a 64-bit write port in the AXI style and a downstream bus whose narrowest target is 32 bits wide. It takes one incrementing write burst at a time. It holds every double word of the burst in a local beat store, then replays the burst downstream as a short series of pieces. Each piece is either a single-word write or one multi-word burst. A double word at either end of the burst that does not have all eight byte strobes set is sent as single writes, one for each 32-bit half that has any strobe set. The fully strobed run between those ends goes out as one burst, and its length is worked out from the strobes of the first and last double words.

Each piece is announced by a command that carries the address, a 4-bit byte enable, a burst flag and a length. The piece's data words follow on a separate 32-bit data channel, and the last word is marked. The downstream side reports one completion per piece. The block counts these and returns exactly one write response upstream once every piece has completed. That response signals an error if any piece reported one.

Top module: `wstrb_burst_splitter`

## Requirements
- R1: After reset, `aw_ready` is 1 and `w_ready`, `cmd_valid`, `dw_valid` and `b_valid` are 0.
- R2: Store and forward: `w_ready` rises only after a write address is accepted and stays high until the beat flagged `w_last` is accepted. No command, data word or response is presented while `w_ready` is high.
- R3: A one-beat write is sent as single writes only: one for the lower half (strobe bits 3:0) if it has any strobe set, then one for the upper half (strobe bits 7:4) if it has any strobe set.
- R4: In a write of two or more beats, a first or last beat whose strobe is not 8'hFF is sent as singles, one per half that has any strobe set. The fully strobed beats between them go out as one burst if they number two or more, and otherwise as one single per half. Pieces are issued in ascending address order.
- R5: A single has `cmd_burst`=0, `cmd_len`=0 and a nonzero `cmd_be` equal to its half's strobes. Its `cmd_addr` is the word address of that half, with bits 1:0 set to the index of the lowest set bit of `cmd_be`.
- R6: A burst has `cmd_burst`=1, `cmd_be`=4'hF and `cmd_len` = 2×(beats covered) − 1. Its `cmd_addr` is the byte address of its first beat.
- R7: Address stepping: after a single at A, the next piece's word address is at least (A+4) with bits 1:0 cleared. After a burst at A, it is at least A + 4×(`cmd_len`+1). The two are equal when no empty half lies between the pieces.
- R8: After each accepted command, exactly `cmd_len`+1 data words follow, lower half before upper half and in ascending beat order, with `dw_last` on the final word. The next command waits until that word is accepted.
- R9: Exactly one response is returned per write. It comes only after every piece has been issued and completed. `b_err` is the OR of the `cpl_err` values of that write's pieces.
- R10: A one-beat write whose strobe is 8'h00 issues no piece and still returns one response with `b_err`=0.
- R11: While `cmd_valid` is 1 and `cmd_ready` is 0, the command stays valid and its fields stay unchanged. While `b_valid` is 1 and `b_ready` is 0, the response and `b_err` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | ADDR_W | Start byte address, 8-byte aligned |
| aw_len | input | 8 | Beats minus one |
| w_valid | input | 1 | Write beat valid |
| w_ready | output | 1 | Write beat ready |
| w_data | input | 64 | Write beat data |
| w_strb | input | 8 | Byte strobes of the beat |
| w_last | input | 1 | Final beat of the write |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_err | output | 1 | Merged error of the write |
| cmd_valid | output | 1 | Piece command valid |
| cmd_ready | input | 1 | Piece command ready |
| cmd_addr | output | ADDR_W | Piece byte address |
| cmd_be | output | 4 | Piece byte enables |
| cmd_burst | output | 1 | 1 = burst piece, 0 = single |
| cmd_len | output | clog2(2·MAX_BEATS) | Piece words minus one |
| dw_valid | output | 1 | Piece data word valid |
| dw_ready | input | 1 | Piece data word ready |
| dw_data | output | 32 | Piece data word |
| dw_last | output | 1 | Final word of the piece |
| cpl_valid | input | 1 | Completion of one piece |
| cpl_err | input | 1 | Error flag of that completion |

## Verification
The assertions take four things as given about the upstream side. The start address is 8-byte aligned. The beat count fits the beat store. `w_last` arrives on exactly the beat that `aw_len` announces. Every beat other than the first and the last is fully strobed. On the downstream side, they take as given that a completion arrives only for a piece whose command has already been accepted. The stimulus sets the strobes of the end beats freely but always drives 8'hFF on the inner beats, and it derives `aw_len` and `w_last` from the same beat count. The responder queues a completion only after it has seen the last data word of a piece.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

   typedef enum logic [1:0] {
      TS_ADDR,
      TS_FILL,
      TS_DRAIN
   } top_state_e;

   typedef enum logic [1:0] {
      PS_IDLE,
      PS_SEL,
      PS_CMD,
      PS_DATA
   } plan_state_e;

   // index of the lowest set byte enable within a 32-bit word
   function automatic logic [1:0] lowest_lane(input logic [3:0] be);
      logic [1:0] idx;
      idx = 2'd0;
      for (int i = 3; i >= 0; i--) begin
         if (be[i]) idx = 2'(i);
      end
      return idx;
   endfunction

endpackage

// File: rtl/wsplit_beat_buf.sv
module wsplit_beat_buf #(
   parameter int DEPTH = 16,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [63:0]      wr_data,
   input  logic [7:0]       wr_strb,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [63:0]      rd_data,
   output logic [7:0]       rd_strb
);

   logic [71:0] store_q [DEPTH];

   initial begin : p_param_check
      assert (DEPTH >= 2);
   end

   always_ff @(posedge clk) begin
      if (wr_en) store_q[wr_idx] <= {wr_strb, wr_data};
   end

   always_comb begin
      rd_data = store_q[rd_idx][63:0];
      rd_strb = store_q[rd_idx][71:64];
   end

endmodule

// File: rtl/wsplit_planner.sv
module wsplit_planner
   import wsplit_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MAX_BEATS = 16,
   localparam int IDX_W  = $clog2(MAX_BEATS),
   localparam int CNT_W  = $clog2(MAX_BEATS + 1),
   localparam int WP_W   = $clog2(2 * MAX_BEATS + 1),
   localparam int DLEN_W = $clog2(2 * MAX_BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  n_beats,
   input  logic              first_full,
   input  logic              last_full,
   input  logic [ADDR_W-1:0] base_addr,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [63:0]       rd_data,
   input  logic [7:0]        rd_strb,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [3:0]        cmd_be,
   output logic              cmd_burst,
   output logic [DLEN_W-1:0] cmd_len,
   output logic              dw_valid,
   input  logic              dw_ready,
   output logic [31:0]       dw_data,
   output logic              dw_last,
   output logic              piece_fire,
   output logic              done
);

   plan_state_e       st_q;
   logic [WP_W-1:0]   wp_q;
   logic [WP_W-1:0]   total_q;
   logic              bst_ok_q;
   logic [WP_W-1:0]   bst_start_q;
   logic [DLEN_W-1:0] bst_len_q;
   logic [DLEN_W-1:0] wcnt_q;
   logic [ADDR_W-1:0] c_addr_q;
   logic [3:0]        c_be_q;
   logic              c_burst_q;
   logic [DLEN_W-1:0] c_len_q;

   // decomposition decided once, when the last beat is stored
   logic              bst_ok_d;
   logic [WP_W-1:0]   bst_start_d;
   logic [DLEN_W-1:0] bst_len_d;
   logic [WP_W-1:0]   total_d;

   always_comb begin
      int n_i, lo_i, hi_i;
      n_i  = int'(n_beats);
      lo_i = first_full ? 0 : 1;
      hi_i = last_full ? n_i - 1 : n_i - 2;
      bst_ok_d    = (n_i > 1) && (hi_i > lo_i);
      bst_start_d = WP_W'(2 * lo_i);
      bst_len_d   = DLEN_W'(2 * (hi_i - lo_i + 1) - 1);
      total_d     = WP_W'(2 * n_i);
   end

   // current word as seen through the beat store
   logic [3:0]        half_be;
   logic [31:0]       half_data;
   logic [ADDR_W-1:0] word_addr;

   always_comb begin
      rd_idx    = IDX_W'(wp_q >> 1);
      half_be   = wp_q[0] ? rd_strb[7:4]   : rd_strb[3:0];
      half_data = wp_q[0] ? rd_data[63:32] : rd_data[31:0];
      word_addr = base_addr + ADDR_W'({wp_q, 2'b00});
   end

   logic sel_end, sel_burst, sel_skip;

   always_comb begin
      sel_end   = (st_q == PS_SEL) && (wp_q >= total_q);
      sel_burst = (st_q == PS_SEL) && !sel_end && bst_ok_q && (wp_q == bst_start_q);
      sel_skip  = (st_q == PS_SEL) && !sel_end && !sel_burst && (half_be == 4'h0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= PS_IDLE;
         wp_q        <= '0;
         total_q     <= '0;
         bst_ok_q    <= 1'b0;
         bst_start_q <= '0;
         bst_len_q   <= '0;
         wcnt_q      <= '0;
         c_addr_q    <= '0;
         c_be_q      <= '0;
         c_burst_q   <= 1'b0;
         c_len_q     <= '0;
      end else begin
         case (st_q)
            PS_IDLE: begin
               if (start) begin
                  wp_q        <= '0;
                  total_q     <= total_d;
                  bst_ok_q    <= bst_ok_d;
                  bst_start_q <= bst_start_d;
                  bst_len_q   <= bst_len_d;
                  st_q        <= PS_SEL;
               end
            end
            PS_SEL: begin
               if (sel_end) begin
                  st_q <= PS_IDLE;
               end else if (sel_burst) begin
                  c_addr_q  <= word_addr;
                  c_be_q    <= 4'hF;
                  c_burst_q <= 1'b1;
                  c_len_q   <= bst_len_q;
                  st_q      <= PS_CMD;
               end else if (sel_skip) begin
                  wp_q <= wp_q + 1'b1;
               end else begin
                  c_addr_q  <= word_addr + ADDR_W'(lowest_lane(half_be));
                  c_be_q    <= half_be;
                  c_burst_q <= 1'b0;
                  c_len_q   <= '0;
                  st_q      <= PS_CMD;
               end
            end
            PS_CMD: begin
               if (cmd_ready) begin
                  wcnt_q <= '0;
                  st_q   <= PS_DATA;
               end
            end
            PS_DATA: begin
               if (dw_ready) begin
                  wp_q   <= wp_q + 1'b1;
                  wcnt_q <= wcnt_q + 1'b1;
                  if (wcnt_q == c_len_q) st_q <= PS_SEL;
               end
            end
            default: st_q <= PS_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_valid  = (st_q == PS_CMD);
      cmd_addr   = c_addr_q;
      cmd_be     = c_be_q;
      cmd_burst  = c_burst_q;
      cmd_len    = c_len_q;
      dw_valid   = (st_q == PS_DATA);
      dw_data    = half_data;
      dw_last    = (wcnt_q == c_len_q);
      piece_fire = cmd_valid && cmd_ready;
      done       = sel_end;
   end

   // ---------------- checks on the emitted pieces ----------------
   logic [DLEN_W:0]   chk_words_q;
   logic [ADDR_W-3:0] chk_next_q;
   logic              chk_have_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_words_q <= '0;
         chk_next_q  <= '0;
         chk_have_q  <= 1'b0;
      end else begin
         if (start && st_q == PS_IDLE) chk_have_q <= 1'b0;
         if (piece_fire) begin
            chk_words_q <= '0;
            chk_next_q  <= cmd_addr[ADDR_W-1:2] + (ADDR_W-2)'(cmd_len) + 1'b1;
            chk_have_q  <= 1'b1;
         end else if (dw_valid && dw_ready) begin
            chk_words_q <= chk_words_q + 1'b1;
         end
      end
   end

   // R5: a single carries one word and at least one byte enable
   a_r5_single_shape: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_burst |-> (cmd_len == '0) && (cmd_be != 4'h0));

   // R7: pieces never step backwards or overlap
   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && chk_have_q |-> cmd_addr[ADDR_W-1:2] >= chk_next_q);

   // R8: the marked last word is word number cmd_len of the piece
   a_r8_word_count: assert property (@(posedge clk) disable iff (!rst_n)
      dw_valid && dw_last |-> chk_words_q == (DLEN_W + 1)'(cmd_len));

   // R8: command and data of a piece never overlap in time
   a_r8_cmd_before_data: assert property (@(posedge clk) disable iff (!rst_n)
      dw_valid |-> !cmd_valid);

   // R11: a stalled command keeps its fields
   a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_be)
                                  && $stable(cmd_len) && $stable(cmd_burst));

endmodule

// File: rtl/wsplit_resp_merge.sv
module wsplit_resp_merge #(
   parameter int MAX_BEATS = 16,
   localparam int PEND_W = $clog2(2 * MAX_BEATS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic piece_fire,
   input  logic plan_done,
   input  logic cpl_valid,
   input  logic cpl_err,
   output logic b_valid,
   input  logic b_ready,
   output logic b_err
);

   logic [PEND_W-1:0] pend_q;
   logic              issued_all_q;
   logic              err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q       <= '0;
         issued_all_q <= 1'b0;
         err_q        <= 1'b0;
      end else begin
         case ({piece_fire, cpl_valid})
            2'b10:   pend_q <= pend_q + 1'b1;
            2'b01:   pend_q <= pend_q - 1'b1;
            default: pend_q <= pend_q;
         endcase
         if (b_valid && b_ready) begin
            issued_all_q <= 1'b0;
            err_q        <= 1'b0;
         end else begin
            if (plan_done) issued_all_q <= 1'b1;
            if (cpl_valid && cpl_err) err_q <= 1'b1;
         end
      end
   end

   always_comb begin
      b_valid = issued_all_q && (pend_q == '0);
      b_err   = err_q;
   end

   // R9: input assumption, a completion only for an accepted piece
   a_r9_cpl_expected: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> (pend_q != '0) || piece_fire);

   // R9: a single response per write
   a_r9_one_resp: assert property (@(posedge clk) disable iff (!rst_n)
      b_valid && b_ready |=> !b_valid);

   // R11: a stalled response keeps its error flag
   a_r11_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      b_valid && !b_ready |=> b_valid && $stable(b_err));

endmodule

// File: rtl/wstrb_burst_splitter.sv
module wstrb_burst_splitter
   import wsplit_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MAX_BEATS = 16,
   localparam int IDX_W  = $clog2(MAX_BEATS),
   localparam int CNT_W  = $clog2(MAX_BEATS + 1),
   localparam int DLEN_W = $clog2(2 * MAX_BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [7:0]        aw_len,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [63:0]       w_data,
   input  logic [7:0]        w_strb,
   input  logic              w_last,
   output logic              b_valid,
   input  logic              b_ready,
   output logic              b_err,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [3:0]        cmd_be,
   output logic              cmd_burst,
   output logic [DLEN_W-1:0] cmd_len,
   output logic              dw_valid,
   input  logic              dw_ready,
   output logic [31:0]       dw_data,
   output logic              dw_last,
   input  logic              cpl_valid,
   input  logic              cpl_err
);

   initial begin : p_param_check
      assert (MAX_BEATS >= 2 && MAX_BEATS <= 256);
      assert (ADDR_W >= DLEN_W + 4);
   end

   top_state_e        st_q;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  nbeats_q;
   logic [CNT_W-1:0]  fill_q;
   logic              first_full_q;

   logic aw_fire, w_fire, b_fire, start;
   logic first_full_in;

   always_comb begin
      aw_ready      = (st_q == TS_ADDR);
      w_ready       = (st_q == TS_FILL);
      aw_fire       = aw_valid && aw_ready;
      w_fire        = w_valid && w_ready;
      b_fire        = b_valid && b_ready;
      start         = w_fire && w_last;
      first_full_in = (fill_q == '0) ? (&w_strb) : first_full_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= TS_ADDR;
         base_q       <= '0;
         nbeats_q     <= '0;
         fill_q       <= '0;
         first_full_q <= 1'b0;
      end else begin
         case (st_q)
            TS_ADDR: begin
               if (aw_fire) begin
                  base_q   <= aw_addr;
                  nbeats_q <= CNT_W'(aw_len) + 1'b1;
                  fill_q   <= '0;
                  st_q     <= TS_FILL;
               end
            end
            TS_FILL: begin
               if (w_fire) begin
                  first_full_q <= first_full_in;
                  fill_q       <= fill_q + 1'b1;
                  if (w_last) st_q <= TS_DRAIN;
               end
            end
            TS_DRAIN: begin
               if (b_fire) st_q <= TS_ADDR;
            end
            default: st_q <= TS_ADDR;
         endcase
      end
   end

   logic [IDX_W-1:0] rd_idx;
   logic [63:0]      rd_data;
   logic [7:0]       rd_strb;
   logic             piece_fire, plan_done;

   wsplit_beat_buf #(.DEPTH(MAX_BEATS)) buf_i (
      .clk     (clk),
      .wr_en   (w_fire),
      .wr_idx  (IDX_W'(fill_q)),
      .wr_data (w_data),
      .wr_strb (w_strb),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .rd_strb (rd_strb)
   );

   wsplit_planner #(.ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS)) plan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .n_beats    (nbeats_q),
      .first_full (first_full_in),
      .last_full  (&w_strb),
      .base_addr  (base_q),
      .rd_idx     (rd_idx),
      .rd_data    (rd_data),
      .rd_strb    (rd_strb),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_addr   (cmd_addr),
      .cmd_be     (cmd_be),
      .cmd_burst  (cmd_burst),
      .cmd_len    (cmd_len),
      .dw_valid   (dw_valid),
      .dw_ready   (dw_ready),
      .dw_data    (dw_data),
      .dw_last    (dw_last),
      .piece_fire (piece_fire),
      .done       (plan_done)
   );

   wsplit_resp_merge #(.MAX_BEATS(MAX_BEATS)) resp_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .piece_fire (piece_fire),
      .plan_done  (plan_done),
      .cpl_valid  (cpl_valid),
      .cpl_err    (cpl_err),
      .b_valid    (b_valid),
      .b_ready    (b_ready),
      .b_err      (b_err)
   );

   // R2: nothing leaves the block while beats are still being stored
   a_r2_store_first: assert property (@(posedge clk) disable iff (!rst_n)
      w_ready |-> !cmd_valid && !dw_valid && !b_valid);

   // R2: w_ready only follows an accepted address
   a_r2_fill_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(w_ready) |-> $past(aw_fire));

   // input assumption: aligned start, beat count fits the store
   a_r4_addr_ok: assert property (@(posedge clk) disable iff (!rst_n)
      aw_fire |-> (aw_addr[2:0] == 3'b000) && (int'(aw_len) < MAX_BEATS));

   // input assumption: w_last on the announced final beat
   a_r4_last_pos: assert property (@(posedge clk) disable iff (!rst_n)
      w_fire |-> w_last == (fill_q == nbeats_q - 1'b1));

   // input assumption: inner beats carry full strobes
   a_r4_inner_full: assert property (@(posedge clk) disable iff (!rst_n)
      w_fire && (fill_q != '0) && !w_last |-> (&w_strb));

endmodule

// File: tb/wstrb_burst_splitter_tb_top.sv
module wstrb_burst_splitter_tb_top;

   localparam int AW   = 32;
   localparam int MB   = 16;
   localparam int LENW = $clog2(2 * MB);

   typedef struct {
      logic [31:0] addr;
      logic [3:0]  be;
      logic        burst;
      int          len;
   } piece_t;

   typedef struct {
      logic [31:0] data;
      logic        last;
   } word_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic aw_valid = 1'b0;
   logic [AW-1:0] aw_addr = '0;
   logic [7:0] aw_len = '0;
   logic w_valid = 1'b0;
   logic [63:0] w_data = '0;
   logic [7:0] w_strb = '0;
   logic w_last = 1'b0;
   logic b_ready = 1'b0;
   logic cmd_ready = 1'b0;
   logic dw_ready = 1'b0;
   logic cpl_valid = 1'b0;
   logic cpl_err = 1'b0;
   logic aw_ready, w_ready, b_valid, b_err, cmd_valid, cmd_burst;
   logic dw_valid, dw_last;
   logic [AW-1:0] cmd_addr;
   logic [3:0] cmd_be;
   logic [LENW-1:0] cmd_len;
   logic [31:0] dw_data;

   always #10 clk = ~clk;

   wstrb_burst_splitter #(.ADDR_W(AW), .MAX_BEATS(MB)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
      .w_last(w_last),
      .b_valid(b_valid), .b_ready(b_ready), .b_err(b_err),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_be(cmd_be), .cmd_burst(cmd_burst), .cmd_len(cmd_len),
      .dw_valid(dw_valid), .dw_ready(dw_ready), .dw_data(dw_data), .dw_last(dw_last),
      .cpl_valid(cpl_valid), .cpl_err(cpl_err)
   );

   int n_checks = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // ---------------- reference model state ----------------
   piece_t      expq[$];
   word_t       wq[$];
   bit          cplq[$];
   logic [63:0] err_mask = '0;
   int          exp_np = 0;
   bit          exp_err = 1'b0;
   int          cmd_seen = 0;
   int          piece_idx = 0;
   int          resp_seen = 0;
   string       cnt_tag = "R4";

   function automatic logic [1:0] low_bit(input logic [3:0] be);
      for (int i = 0; i < 4; i++) if (be[i]) return 2'(i);
      return 2'd0;
   endfunction

   function automatic void build_model(input logic [31:0] addr, input int n,
                                       input logic [63:0] d[MB], input logic [7:0] s[MB]);
      int lo, hi, w;
      bit use_burst;
      lo = (s[0] == 8'hFF) ? 0 : 1;
      hi = (s[n-1] == 8'hFF) ? n - 1 : n - 2;
      use_burst = (n > 1) && (hi > lo);
      w = 0;
      while (w < 2 * n) begin
         if (use_burst && w == 2 * lo) begin
            piece_t p;
            p.addr = addr + 32'(4 * w); p.be = 4'hF; p.burst = 1'b1;
            p.len = 2 * (hi - lo + 1) - 1;
            expq.push_back(p);
            for (int k = 0; k <= p.len; k++) begin
               word_t x;
               x.data = ((w + k) % 2 == 1) ? d[(w + k) / 2][63:32] : d[(w + k) / 2][31:0];
               x.last = (k == p.len);
               wq.push_back(x);
            end
            w = w + p.len + 1;
         end else begin
            logic [3:0] be;
            be = (w % 2 == 1) ? s[w / 2][7:4] : s[w / 2][3:0];
            if (be != 4'h0) begin
               piece_t p;
               word_t x;
               p.addr = addr + 32'(4 * w) + 32'(low_bit(be));
               p.be = be; p.burst = 1'b0; p.len = 0;
               expq.push_back(p);
               x.data = (w % 2 == 1) ? d[w / 2][63:32] : d[w / 2][31:0];
               x.last = 1'b1;
               wq.push_back(x);
            end
            w = w + 1;
         end
      end
   endfunction

   // ---------------- downstream and response responder ----------------
   always @(posedge clk) begin
      #1;
      cmd_ready = ($urandom % 4) != 0;
      dw_ready  = ($urandom % 4) != 0;
      b_ready   = ($urandom % 3) != 0;
      if (cplq.size() > 0 && ($urandom % 2) == 1) begin
         cpl_valid = 1'b1;
         cpl_err   = cplq.pop_front();
      end else begin
         cpl_valid = 1'b0;
         cpl_err   = 1'b0;
      end
   end

   // ---------------- monitor, compared on every clock ----------------
   bit          hold_q = 1'b0;
   logic [31:0] hold_addr;
   logic [3:0]  hold_be;
   logic [LENW-1:0] hold_len;
   logic        hold_burst;

   always @(negedge clk) begin
      if (rst_n) begin
         if (w_ready)
            check(!cmd_valid && !dw_valid && !b_valid, "R2", "output while filling",
                  {cmd_valid, dw_valid, b_valid}, 0);
         if (hold_q)
            check(cmd_valid && cmd_addr == hold_addr && cmd_be == hold_be &&
                  cmd_len == hold_len && cmd_burst == hold_burst, "R11", "stalled command",
                  cmd_addr, hold_addr);
         hold_q = cmd_valid && !cmd_ready;
         hold_addr = cmd_addr; hold_be = cmd_be; hold_len = cmd_len; hold_burst = cmd_burst;
         if (cmd_valid && cmd_ready) begin
            cmd_seen++;
            if (expq.size() == 0) begin
               check(1'b0, cnt_tag, "unexpected piece", cmd_addr, 0);
            end else begin
               piece_t p;
               p = expq.pop_front();
               check(cmd_burst == p.burst && cmd_be == p.be && int'(cmd_len) == p.len,
                     p.burst ? "R6" : "R5", "piece shape",
                     {cmd_burst, cmd_be, 8'(cmd_len)}, {p.burst, p.be, 8'(p.len)});
               check(cmd_addr == p.addr, "R7", "piece address", cmd_addr, p.addr);
            end
         end
         if (dw_valid && dw_ready) begin
            if (wq.size() == 0) begin
               check(1'b0, "R8", "unexpected data word", dw_data, 0);
            end else begin
               word_t x;
               x = wq.pop_front();
               check(dw_data == x.data && dw_last == x.last, "R8", "data word",
                     {dw_last, dw_data}, {x.last, x.data});
            end
            if (dw_last) begin
               cplq.push_back(err_mask[piece_idx % 64]);
               piece_idx++;
            end
         end
         if (b_valid) begin
            check(cplq.size() == 0 && !cpl_valid && wq.size() == 0, "R9",
                  "response before completions", cplq.size(), 0);
            if (b_ready) begin
               check(b_err == exp_err, "R9", "merged error", b_err, exp_err);
               check(cmd_seen == exp_np && expq.size() == 0, cnt_tag, "piece count",
                     cmd_seen, exp_np);
               resp_seen++;
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic run_burst(input logic [31:0] addr, input int n,
                            input logic [7:0] s_first, input logic [7:0] s_last,
                            input logic [63:0] emask);
      logic [63:0] d[MB];
      logic [7:0]  s[MB];
      int          seen0;
      for (int i = 0; i < MB; i++) begin
         d[i] = {$urandom, $urandom};
         s[i] = 8'hFF;
      end
      s[0] = s_first;
      if (n > 1) s[n-1] = s_last;
      err_mask = emask;
      cmd_seen = 0;
      piece_idx = 0;
      build_model(addr, n, d, s);
      exp_np = expq.size();
      exp_err = 1'b0;
      for (int k = 0; k < exp_np; k++) exp_err |= emask[k];
      cnt_tag = (n > 1) ? "R4" : ((s_first == 8'h00) ? "R10" : "R3");
      seen0 = resp_seen;
      @(posedge clk); #1;
      aw_valid = 1'b1; aw_addr = addr; aw_len = 8'(n - 1);
      do @(negedge clk); while (!aw_ready);
      @(posedge clk); #1;
      aw_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         w_valid = 1'b1; w_data = d[i]; w_strb = s[i]; w_last = (i == n - 1);
         do @(negedge clk); while (!w_ready);
         @(posedge clk); #1;
      end
      w_valid = 1'b0; w_last = 1'b0;
      while (resp_seen == seen0) @(negedge clk);
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "R9", "watchdog expired", cycles, 150000);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(aw_ready && !w_ready && !cmd_valid && !dw_valid && !b_valid, "R1", "reset state",
            {aw_ready, w_ready, cmd_valid, dw_valid, b_valid}, 5'b10000);

      run_burst(32'h0000_1000, 1, 8'hFF, 8'hFF, 64'h0);   // R3 two singles
      run_burst(32'h0000_1008, 1, 8'h60, 8'hFF, 64'h0);   // R3 upper only, lane 1
      run_burst(32'h0000_1010, 1, 8'h00, 8'hFF, 64'h1);   // R10 nothing issued
      run_burst(32'h0000_1018, 1, 8'h0C, 8'hFF, 64'h0);   // R5 lane 2
      run_burst(32'h0000_2000, 2, 8'hFF, 8'hFF, 64'h0);   // R6 burst of 4 words
      run_burst(32'h0000_2100, 2, 8'hF0, 8'hFF, 64'h0);   // R4 short run as singles
      run_burst(32'h0000_2200, 3, 8'hE0, 8'h07, 64'h0);   // R4 all singles
      run_burst(32'h0000_2300, 4, 8'h80, 8'hFF, 64'h0);   // R7 single then burst
      run_burst(32'h0000_3000, 16, 8'hFF, 8'hFF, 64'h0);  // R6 full length
      run_burst(32'h0000_4000, 16, 8'h3F, 8'hFE, 64'h0);  // R4 five pieces
      run_burst(32'h0000_5000, 5, 8'h0F, 8'hF0, 64'h4);   // R9 error merge

      for (int t = 0; t < 40; t++) begin
         logic [31:0] a;
         logic [63:0] em;
         int n;
         a  = $urandom & 32'h00FF_FFF8;
         n  = 1 + int'($urandom % MB);
         em = (($urandom % 4) == 0) ? (64'h1 << ($urandom % 8)) : 64'h0;
         run_burst(a, n, 8'($urandom), 8'($urandom), em);
      end

      repeat (5) @(posedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule